// File: doc/BRIEF.md
# Two-Channel DAC Command Decoder

This block is the digital core of a two-channel digital-to-analog converter that is controlled over a serial slave link. A host lowers `cs_n` and clocks a 16-bit frame on `sdi`, one bit per rising edge of `sclk`. Each frame carries a 4-bit command and a 10-bit code. The block decodes the command when `cs_n` rises again, and only if exactly sixteen bits arrived.

Each channel has two registers. A staging register takes new codes. An output register drives the converter, and its value appears on `dac_a_o` and `dac_b_o`. Commands can stage a code, move staged codes into the output registers, or do both at once. Other commands wake the part or put it to sleep.

While the part sleeps, `drive_en_o` is low. This flag stands for the high-impedance state of the analog outputs. The serial pins are sampled with the core clock through two-stage synchronizers, so `sclk` must be several times slower than `clk`.

Top module: `dac_cmd_core`

## Requirements
- R1: After reset, both staging registers and both output registers are zero, `dac_a_o` and `dac_b_o` read 0, and `drive_en_o` is 0 (asleep).
- R2: While `cs_n` is low, one bit is taken from `sdi` at each rising edge of `sclk`, MSB first. Of the 16 bits, bits 15..12 are the command, bits 11..2 are the code, and bits 1..0 are ignored.
- R3: A frame executes at the rising edge of `cs_n` only when exactly 16 `sclk` rising edges were seen while `cs_n` was low. Frames of 15 or 17 bits change nothing.
- R4: Command 0000 and the reserved commands (0011, 0100, 0101, 0110, 0111, 1011, 1100) leave all registers and the sleep state unchanged.
- R5: Command 0001 loads the code into staging register A, and 0010 loads it into staging register B. Outputs and sleep state stay unchanged.
- R6: Command 1000 copies both staging registers into the output registers and sets `drive_en_o`.
- R7: Command 1001 loads the code into staging A, then sets output A to the code and output B to staging B, and wakes. Command 1010 is the mirror: it loads staging B, sets output B to the code and output A to staging A, and wakes.
- R8: Command 1101 sets `drive_en_o` and leaves all four registers unchanged.
- R9: Command 1110 clears `drive_en_o` and leaves all four registers unchanged. The outputs keep showing the output registers.
- R10: Command 1111 loads the code into both staging registers and both output registers, and wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| dac_a_o | output | 10 | Output register of channel A |
| dac_b_o | output | 10 | Output register of channel B |
| drive_en_o | output | 1 | High while awake; low stands for high-impedance outputs |

## Verification
The assertions assume three things about the serial inputs. `sclk` and `cs_n` each hold every level for at least two core clock cycles. `sdi` is settled before each `sclk` rise. The frame's code is observed only through the decoded result after `cs_n` rises.

The stimulus keeps to these assumptions. Every `sclk` phase and every `cs_n` gap lasts four core cycles. Inputs change only on the falling core clock edge, and `sdi` changes only while `sclk` is low.

Random frames draw every one of the sixteen commands. Some random frames deliberately carry 15 or 17 bits to exercise the length rule.

// File: rtl/dac_cmd_core.sv
module dac_cmd_core #(
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              drive_en_o
);
  localparam int CMD_W   = 4;
  localparam int FRAME_W = CMD_W + DATA_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  localparam logic [3:0] OP_LD_A   = 4'b0001;
  localparam logic [3:0] OP_LD_B   = 4'b0010;
  localparam logic [3:0] OP_XFER   = 4'b1000;
  localparam logic [3:0] OP_LDUP_A = 4'b1001;
  localparam logic [3:0] OP_LDUP_B = 4'b1010;
  localparam logic [3:0] OP_WAKE   = 4'b1101;
  localparam logic [3:0] OP_SLEEP  = 4'b1110;
  localparam logic [3:0] OP_BOTH   = 4'b1111;

  logic [2:0]         sclk_s, csn_s;
  logic [1:0]         sdi_s;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  stg_a, stg_b, out_a, out_b;
  logic               awake;

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire cs_rise   = csn_s[1] & ~csn_s[2];
  wire fire      = cs_rise && (bit_cnt == CNT_FULL);
  wire [CMD_W-1:0]  cmd  = shreg[FRAME_W-1 -: CMD_W];
  wire [DATA_W-1:0] code = shreg[PAD_W +: DATA_W];

  assign dac_a_o    = out_a;
  assign dac_b_o    = out_b;
  assign drive_en_o = awake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      csn_s  <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      csn_s  <= {csn_s[1:0], cs_n};
      sdi_s  <= {sdi_s[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (csn_s[1]) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_W-2:0], sdi_s[1]};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a <= '0;
      stg_b <= '0;
      out_a <= '0;
      out_b <= '0;
      awake <= 1'b0;
    end else if (fire) begin
      unique case (cmd)
        OP_LD_A: stg_a <= code;
        OP_LD_B: stg_b <= code;
        OP_XFER: begin
          out_a <= stg_a;
          out_b <= stg_b;
          awake <= 1'b1;
        end
        OP_LDUP_A: begin
          stg_a <= code;
          out_a <= code;
          out_b <= stg_b;
          awake <= 1'b1;
        end
        OP_LDUP_B: begin
          stg_b <= code;
          out_a <= stg_a;
          out_b <= code;
          awake <= 1'b1;
        end
        OP_WAKE:  awake <= 1'b1;
        OP_SLEEP: awake <= 1'b0;
        OP_BOTH: begin
          stg_a <= code;
          stg_b <= code;
          out_a <= code;
          out_b <= code;
          awake <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_cmd_core_chk.sv
module dac_cmd_core_chk #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 5,
  parameter int FRAME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic [3:0]        cmd,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              en
);
  wire reserved = (cmd == 4'b0000) || (cmd == 4'b0011) || (cmd[3:2] == 2'b01) ||
                  (cmd == 4'b1011) || (cmd == 4'b1100);
  wire waking   = (cmd == 4'b1000) || (cmd == 4'b1001) || (cmd == 4'b1010) ||
                  (cmd == 4'b1101) || (cmd == 4'b1111);

  assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W + 1));

  assert_out_change_needs_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a) || !$stable(dac_b) || !$stable(en)) |-> $past(fire));

  assert_reserved_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && reserved) |=> ($stable(dac_a) && $stable(dac_b) && $stable(en)));

  assert_load_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (cmd == 4'b0001 || cmd == 4'b0010)) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(en)));

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && waking) |=> en);

  assert_wake_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == 4'b1101) |=> ($stable(dac_a) && $stable(dac_b)));

  assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == 4'b1110) |=> (!en && $stable(dac_a) && $stable(dac_b)));

  assert_both_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd == 4'b1111) |=> (dac_a == dac_b));
endmodule

bind dac_cmd_core dac_cmd_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(cmd), .cnt(bit_cnt),
  .dac_a(dac_a_o), .dac_b(dac_b_o), .en(drive_en_o)
);

// File: tb/dac_cmd_core_bench.sv
module dac_cmd_core_bench;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [9:0] dac_a_o, dac_b_o;
  logic drive_en_o;
  int checks = 0, errors = 0;
  logic [9:0] m_sa, m_sb, m_oa, m_ob;
  logic m_en;

  always #5 clk = ~clk;

  dac_cmd_core u_dac_cmd_core (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .dac_a_o(dac_a_o), .dac_b_o(dac_b_o), .drive_en_o(drive_en_o)
  );

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [3:0] c, int n);
    if (n != 16) return "R3";
    case (c)
      4'h1, 4'h2: return "R5";
      4'h8: return "R6";
      4'h9, 4'hA: return "R7";
      4'hD: return "R8";
      4'hE: return "R9";
      4'hF: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic model_apply(logic [3:0] c, logic [9:0] d);
    case (c)
      4'h1: m_sa = d;
      4'h2: m_sb = d;
      4'h8: begin m_oa = m_sa; m_ob = m_sb; m_en = 1; end
      4'h9: begin m_sa = d; m_oa = d; m_ob = m_sb; m_en = 1; end
      4'hA: begin m_sb = d; m_oa = m_sa; m_ob = d; m_en = 1; end
      4'hD: m_en = 1;
      4'hE: m_en = 0;
      4'hF: begin m_sa = d; m_sb = d; m_oa = d; m_ob = d; m_en = 1; end
      default: ;
    endcase
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [3:0] c, logic [9:0] d, int nbits);
    logic [16:0] w;
    string r;
    w = {c, d, 2'($urandom), 1'($urandom)};
    if (nbits == 16) w = {1'b0, c, d, 2'($urandom)};
    cs_n = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(4);
    cs_n = 1'b1;
    tick(8);
    if (nbits == 16) model_apply(c, d);
    r = req_of(c, nbits);
    check({r, " R2 out_a"}, dac_a_o, m_oa);
    check({r, " R2 out_b"}, dac_b_o, m_ob);
    check({r, " en"}, {9'd0, drive_en_o}, {9'd0, m_en});
  endtask

  initial begin
    void'($urandom(32'd4711));
    m_sa = 0; m_sb = 0; m_oa = 0; m_ob = 0; m_en = 0;
    tick(3);
    check("R1 out_a", dac_a_o, 10'd0);
    check("R1 out_b", dac_b_o, 10'd0);
    check("R1 en", {9'd0, drive_en_o}, 10'd0);
    rst_n = 1'b1;
    tick(4);
    check("R1 en after release", {9'd0, drive_en_o}, 10'd0);

    send(4'h1, 10'h2A5, 16);
    send(4'h2, 10'h15A, 16);
    send(4'hD, 10'h3FF, 16);
    send(4'h8, 10'h000, 16);
    send(4'hE, 10'h111, 16);
    send(4'h9, 10'h3C3, 16);
    send(4'hE, 10'h000, 16);
    send(4'hA, 10'h001, 16);
    send(4'h3, 10'h3FF, 16);
    send(4'hB, 10'h0F0, 16);
    send(4'hC, 10'h0F0, 16);
    send(4'h0, 10'h0F0, 16);
    send(4'hF, 10'h200, 15);
    send(4'hF, 10'h200, 17);
    send(4'hF, 10'h3FE, 16);
    send(4'hE, 10'h000, 16);
    send(4'h1, 10'h055, 16);
    send(4'hD, 10'h000, 16);
    send(4'h8, 10'h000, 16);

    for (int k = 0; k < 60; k++) begin
      int nb;
      nb = 16;
      if ($urandom % 8 == 0) nb = ($urandom % 2) ? 15 : 17;
      send(4'($urandom), 10'($urandom), nb);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule